// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a memory read or write burst. The controller presents a starting column together with a one-cycle start strobe. The block takes the burst length, the wrap order and the single-write option from mode fields held elsewhere. From then on it steps through the columns of the burst, one per clock. It marks each beat as valid and flags the final beat.

Two wrap orders are supported. In the counting order, the low bits inside the burst window advance and wrap. In the XOR order, the beat number is XORed into the low bits. A page mode walks the whole column space and keeps going until the controller stops it. A burst can be cut off on any clock in two ways: a terminate strobe ends it, or a new start replaces it and begins its own first beat in that same cycle.

Top module: `bcs_burst_colseq`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), with `start` low, `beat_valid` and `last_beat` are 0 and `col` is 0. A burst in progress when reset is applied is abandoned.
- R2: `len_code` sets the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives page mode. The reserved codes 4, 5 and 6 give a single beat.
- R3: With `interleave` low, beat n has low log2(length) bits equal to (start low bits + n) modulo the length. The bits above that window equal those of `start_col`.
- R4: With `interleave` high and a length of 2, 4 or 8, beat n has low bits equal to the start low bits XOR n. The upper bits are unchanged.
- R5: Page mode always uses the counting order, whatever `interleave` says. It wraps from the highest column to 0, runs until it is terminated or replaced, and never raises `last_beat`.
- R6: The first beat appears combinationally in the cycle `start` is high, with `col` equal to `start_col`. For a one-beat burst, `beat_valid` and `last_beat` are both high in that cycle.
- R7: `last_beat` is high only on the final beat of a finite burst. In the following cycle `beat_valid` is low unless `start` is high.
- R8: In a cycle where `terminate` is high and `start` is low, `beat_valid` is low. The burst does not resume afterwards. A terminate while idle has no effect.
- R9: A `start` during a running burst replaces that burst: the new first beat appears in that same cycle. `start` takes priority over `terminate` when both are high.
- R10: When `is_write` and `single_write` are both high, the burst is one beat, whatever the length code. Reads ignore `single_write`, and writes with `single_write` low use the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new burst this cycle |
| start_col | input | COL_W | First column of the burst |
| is_write | input | 1 | The burst being started is a write |
| len_code | input | 3 | Burst length code (see R2) |
| interleave | input | 1 | 1 selects the XOR wrap order |
| single_write | input | 1 | Force writes to one beat |
| terminate | input | 1 | Stop the running burst |
| col | output | COL_W | Column of the current beat, 0 when idle |
| beat_valid | output | 1 | A beat is issued this cycle |
| last_beat | output | 1 | This beat is the final one of a finite burst |

## Verification
The bench builds the block with the default 8-bit column. This keeps a page burst short enough to be followed past the wrap from 255 to 0 and through several hundred beats without a last flag. The start columns sit in the middle of 2-, 4- and 8-beat windows, so both wrap orders visibly fold back below the start column. Replacement, terminate and mid-burst reset are each driven at a chosen beat of a longer burst.

// File: rtl/bcs_pkg.sv
// Shared definitions for the burst column sequencer.
// Assumes a 3-bit length code field in the mode settings.
package bcs_pkg;
    typedef enum logic [2:0] {
        LEN_ONE   = 3'd0,
        LEN_TWO   = 3'd1,
        LEN_FOUR  = 3'd2,
        LEN_EIGHT = 3'd3,
        LEN_PAGE  = 3'd7
    } len_code_e;
endpackage

// File: rtl/bcs_mode_decode.sv
// Turns the mode fields of a burst being started into a window mask,
// a page-mode flag and a wrap-order select.
// Assumes COL_W >= 3 so that an 8-beat window fits.
module bcs_mode_decode #(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_code,
    input  logic             interleave_req,
    input  logic             is_write,
    input  logic             single_write,
    output logic [COL_W-1:0] span_mask,
    output logic             page_mode,
    output logic             use_xor
);
    import bcs_pkg::*;

    // Decode the length code, then apply the single-beat write override.
    always_comb begin
        span_mask = '0;
        page_mode = 1'b0;
        case (len_code_e'(len_code))
            LEN_TWO:   span_mask = COL_W'(1);
            LEN_FOUR:  span_mask = COL_W'(3);
            LEN_EIGHT: span_mask = COL_W'(7);
            LEN_PAGE: begin
                span_mask = '1;
                page_mode = 1'b1;
            end
            default:   span_mask = '0;
        endcase
        if (is_write && single_write) begin
            span_mask = '0;
            page_mode = 1'b0;
        end
        use_xor = interleave_req && !page_mode;
    end
endmodule

// File: rtl/bcs_col_gen.sv
// Forms the column of beat number beat_idx from the base column.
// Bits inside span_mask follow the chosen order; bits above it are kept.
// Assumes span_mask is a contiguous run of ones from bit 0.
module bcs_col_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_idx,
    input  logic [COL_W-1:0] span_mask,
    input  logic             use_xor,
    output logic [COL_W-1:0] col_out
);
    logic [COL_W-1:0] inner;

    // Candidate low bits under either wrap order.
    always_comb begin
        inner = use_xor ? (base_col ^ beat_idx) : (base_col + beat_idx);
    end

    // Per-bit choice between the stepped window and the fixed upper bits.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_out[b] = span_mask[b] ? inner[b] : base_col[b];
    end
endmodule

// File: rtl/bcs_burst_colseq.sv
// Burst column sequencer top. Issues one column per clock for a burst.
// The first beat is combinational from start, later beats come from
// held state. A terminate or a fresh start ends a running burst at once.
// Assumes the mode fields are stable while start is high.
module bcs_burst_colseq #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             is_write,
    input  logic [2:0]       len_code,
    input  logic             interleave,
    input  logic             single_write,
    input  logic             terminate,
    output logic [COL_W-1:0] col,
    output logic             beat_valid,
    output logic             last_beat
);
    logic             run_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] mask_q;
    logic             page_q;
    logic             xor_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             dec_xor;

    logic [COL_W-1:0] sel_base;
    logic [COL_W-1:0] sel_idx;
    logic [COL_W-1:0] sel_mask;
    logic             sel_page;
    logic             sel_xor;
    logic [COL_W-1:0] gen_col;
    logic             at_end;

    bcs_mode_decode #(.COL_W(COL_W)) i_decode (
        .len_code       (len_code),
        .interleave_req (interleave),
        .is_write       (is_write),
        .single_write   (single_write),
        .span_mask      (dec_mask),
        .page_mode      (dec_page),
        .use_xor        (dec_xor)
    );

    // Pick the live configuration: fresh decode on start, held otherwise.
    always_comb begin
        sel_base = start ? start_col : base_q;
        sel_idx  = start ? '0        : idx_q;
        sel_mask = start ? dec_mask  : mask_q;
        sel_page = start ? dec_page  : page_q;
        sel_xor  = start ? dec_xor   : xor_q;
    end

    bcs_col_gen #(.COL_W(COL_W)) i_colgen (
        .base_col  (sel_base),
        .beat_idx  (sel_idx),
        .span_mask (sel_mask),
        .use_xor   (sel_xor),
        .col_out   (gen_col)
    );

    // Output beat flags and column.
    always_comb begin
        at_end     = !sel_page && (sel_idx == sel_mask);
        beat_valid = start || (run_q && !terminate);
        last_beat  = beat_valid && at_end;
        col        = beat_valid ? gen_col : '0;
    end

    // Burst state: capture on start, step each beat, stop on end or terminate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            base_q <= '0;
            idx_q  <= '0;
            mask_q <= '0;
            page_q <= 1'b0;
            xor_q  <= 1'b0;
        end else if (start) begin
            run_q  <= !at_end;
            base_q <= start_col;
            idx_q  <= COL_W'(1);
            mask_q <= dec_mask;
            page_q <= dec_page;
            xor_q  <= dec_xor;
        end else if (run_q) begin
            if (terminate || at_end) begin
                run_q <= 1'b0;
            end else begin
                idx_q <= idx_q + COL_W'(1);
            end
        end
    end

    // R6: the start cycle presents the start column as a valid beat.
    a_r6_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (beat_valid && col == start_col));

    // R7: nothing is issued after a final beat unless a new burst starts.
    a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> (start || !beat_valid));

    // R8: a terminate without a start silences this and the following beats.
    a_r8_term_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (terminate && !start) |-> !beat_valid);
    a_r8_term_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (terminate && !start) |=> (start || !beat_valid));

    // R9: a non-final beat is followed by another beat unless terminated.
    a_r9_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !last_beat) |=> (beat_valid || terminate));

    // R5: a held page burst never flags a last beat.
    a_r5_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && page_q && !start) |-> !last_beat);

    // R3: bits above the burst window stay equal to the start column.
    a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !start && !terminate) |-> ((col & ~mask_q) == (base_q & ~mask_q)));
endmodule

// File: tb/test_bcs_burst_colseq.sv
`timescale 1ns/1ps
module test_bcs_burst_colseq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic       is_write = 1'b0;
    logic [2:0] len_code = '0;
    logic       interleave = 1'b0;
    logic       single_write = 1'b0;
    logic       terminate = 1'b0;
    logic [7:0] col;
    logic       beat_valid;
    logic       last_beat;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    bcs_burst_colseq #(.COL_W(8)) i_bcs_burst_colseq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .is_write(is_write), .len_code(len_code), .interleave(interleave),
        .single_write(single_write), .terminate(terminate),
        .col(col), .beat_valid(beat_valid), .last_beat(last_beat)
    );

    typedef struct packed {
        logic [2:0] code;
        logic       il;
        logic       sw;
        logic       wr;
        logic [7:0] scol;
        logic [3:0] beats;
        logic [7:0] lastcol;
    } vec_t;

    // Burst table: mode, start column, expected beat count and final column.
    localparam vec_t VEC [11] = '{
        '{3'd0, 1'b0, 1'b0, 1'b0, 8'h37, 4'd1, 8'h37},
        '{3'd1, 1'b0, 1'b0, 1'b0, 8'h37, 4'd2, 8'h36},
        '{3'd2, 1'b0, 1'b0, 1'b0, 8'h5E, 4'd4, 8'h5D},
        '{3'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 4'd8, 8'hA4},
        '{3'd3, 1'b1, 1'b0, 1'b0, 8'hA5, 4'd8, 8'hA2},
        '{3'd2, 1'b1, 1'b0, 1'b0, 8'h5E, 4'd4, 8'h5D},
        '{3'd1, 1'b1, 1'b0, 1'b0, 8'h10, 4'd2, 8'h11},
        '{3'd3, 1'b0, 1'b1, 1'b1, 8'hA5, 4'd1, 8'hA5},
        '{3'd3, 1'b0, 1'b0, 1'b1, 8'hA5, 4'd8, 8'hA4},
        '{3'd2, 1'b0, 1'b1, 1'b0, 8'h5E, 4'd4, 8'h5D},
        '{3'd5, 1'b0, 1'b0, 1'b0, 8'h42, 4'd1, 8'h42}
    };

    function automatic logic [7:0] model_col(input logic [7:0] b, input logic [2:0] code,
                                             input logic il, input logic wr, input logic sw,
                                             input int n);
        logic [7:0] m;
        logic [7:0] lo;
        logic       pg;
        pg = (code == 3'd7);
        m  = (code == 3'd1) ? 8'h01 : (code == 3'd2) ? 8'h03 :
             (code == 3'd3) ? 8'h07 : pg ? 8'hFF : 8'h00;
        if (wr && sw) begin
            m  = 8'h00;
            pg = 1'b0;
        end
        lo = (il && !pg) ? (b ^ 8'(n)) : (b + 8'(n));
        return (b & ~m) | (lo & m);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic begin_burst(input logic [2:0] code, input logic il, input logic sw,
                               input logic wr, input logic [7:0] sc);
        @(negedge clk);
        len_code = code; interleave = il; single_write = sw; is_write = wr;
        start_col = sc; start = 1'b1; terminate = 1'b0;
        #1;
    endtask

    task automatic next_beat();
        @(negedge clk);
        start = 1'b0;
        terminate = 1'b0;
        #1;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(beat_valid, 0, "R1 valid after reset");
        chk(last_beat, 0, "R1 last after reset");
        chk(col, 0, "R1 col after reset");

        // R2 R3 R4 R6 R7 R10: table walk
        foreach (VEC[k]) begin
            begin_burst(VEC[k].code, VEC[k].il, VEC[k].sw, VEC[k].wr, VEC[k].scol);
            for (int n = 0; n < 16; n++) begin
                if (n > 0) next_beat();
                chk(beat_valid, 1, "R2 R6 beat valid");
                chk(col, model_col(VEC[k].scol, VEC[k].code, VEC[k].il, VEC[k].wr, VEC[k].sw, n),
                    "R3 R4 beat column");
                chk(last_beat, (n == int'(VEC[k].beats) - 1), "R7 R10 last flag");
                if (n == int'(VEC[k].beats) - 1) begin
                    chk(col, VEC[k].lastcol, "R3 R4 final column");
                    break;
                end
            end
            next_beat();
            chk(beat_valid, 0, "R7 idle after last");
        end

        // R5: page burst, XOR order requested but counting used, wraps, no last
        begin_burst(3'd7, 1'b1, 1'b0, 1'b0, 8'hFE);
        for (int n = 0; n < 300; n++) begin
            if (n > 0) next_beat();
            chk({beat_valid, last_beat, col}, {1'b1, 1'b0, 8'(8'hFE + n)}, "R5 page beat");
        end
        // R8: terminate ends the page burst immediately
        @(negedge clk);
        terminate = 1'b1;
        #1;
        chk(beat_valid, 0, "R8 terminate cycle");
        next_beat();
        chk(beat_valid, 0, "R8 stays idle");
        // R8: terminate while idle does nothing
        @(negedge clk);
        terminate = 1'b1;
        #1;
        chk(beat_valid, 0, "R8 idle terminate");
        next_beat();
        begin_burst(3'd1, 1'b0, 1'b0, 1'b0, 8'h06);
        chk(col, 8'h06, "R8 start after idle terminate");
        next_beat();
        chk({last_beat, col}, {1'b1, 8'h07}, "R8 burst after idle terminate");
        next_beat();

        // R8: terminate after two beats of an 8-beat burst
        begin_burst(3'd3, 1'b0, 1'b0, 1'b0, 8'h30);
        next_beat();
        chk(col, 8'h31, "R8 second beat");
        @(negedge clk);
        terminate = 1'b1;
        #1;
        chk(beat_valid, 0, "R8 mid burst terminate");
        next_beat();
        chk(beat_valid, 0, "R8 no resume");

        // R9: replacement by a new start during an 8-beat burst
        begin_burst(3'd3, 1'b0, 1'b0, 1'b0, 8'h20);
        next_beat();
        next_beat();
        chk(col, 8'h22, "R9 third beat of first burst");
        begin_burst(3'd2, 1'b0, 1'b0, 1'b0, 8'h41);
        chk({beat_valid, last_beat, col}, {1'b1, 1'b0, 8'h41}, "R9 new first beat");
        next_beat();
        chk(col, 8'h42, "R9 second beat");
        next_beat();
        chk(col, 8'h43, "R9 third beat");
        next_beat();
        chk({last_beat, col}, {1'b1, 8'h40}, "R9 wrapped last beat");
        next_beat();
        chk(beat_valid, 0, "R9 idle after replaced burst");

        // R9: start wins over terminate in the same cycle
        begin_burst(3'd2, 1'b0, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        start = 1'b1; terminate = 1'b1; len_code = 3'd1; start_col = 8'h81;
        #1;
        chk({beat_valid, col}, {1'b1, 8'h81}, "R9 start beats terminate");
        next_beat();
        chk({beat_valid, last_beat, col}, {1'b1, 1'b1, 8'h80}, "R9 replacing burst completes");
        next_beat();
        chk(beat_valid, 0, "R9 idle after");

        // R1: reset in the middle of a burst abandons it
        begin_burst(3'd3, 1'b0, 1'b0, 1'b0, 8'h50);
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk({beat_valid, last_beat, col}, 10'd0, "R1 reset mid burst");
        next_beat();
        chk(beat_valid, 0, "R1 stays idle after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule